// File: doc/BRIEF.md
# Serial NOR Flash Program and Erase Sequencer

This block sits on the host side of a single-bit SPI link to a serial NOR flash. It turns one high-level request into the full series of bus transactions the flash needs. A request is either a program of a byte stream starting at an address, or an erase at one of three sizes: a small block, a large block, or the whole array. Requests arrive on a valid/ready handshake. The data bytes for a program request arrive on a second valid/ready stream, one byte per beat.

Before each operation the sequencer sends a one-byte write-enable transaction. It then sends the operation itself. After that it reads the flash status register in repeated short transactions until the busy bit reads clear. A program request whose range runs past the end of a flash page is cut into several page-sized bursts. Each burst gets its own write-enable and its own status polling. A single-cycle completion pulse marks the end of the whole request. The target area has to be erased (all bytes 0xFF) before it is programmed, because programming can only clear bits.

Top module: `spi_nor_pe_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `busy` is 0, `done` is 0 and `req_ready` is 1.
- R2: Every program or erase transaction follows its own one-byte transaction carrying opcode 0x06, with chip select high between the two.
- R3: A program burst is opcode 0x02, then three address bytes with the most significant byte first, then the data bytes in stream order. Each data byte lands at consecutive addresses.
- R4: No program burst crosses a 256-byte page. The first burst carries min(len, 256 - addr[7:0]) bytes, and later bursts start page-aligned with at most 256 bytes.
- R5: `req_op` 1 sends 0x20 and `req_op` 2 sends 0xD8, each followed by three address bytes MSB first. `req_op` 3 sends the single byte 0xC7 with no address. `req_op` 0 is program.
- R6: After each operation, the block runs status transactions (0x05 followed by one read byte). It repeats them while bit 0 of the returned byte is 1, and moves on only after a read with bit 0 equal to 0.
- R7: The bus runs SPI mode 0. SCK is low whenever chip select is high. MOSI is sampled by the flash on the rising SCK edge, and every SCK high and low phase inside a byte lasts `CLK_DIV` clock cycles.
- R8: `req_ready` is high only while idle. A request is taken when `req_valid` and `req_ready` are both high, and `busy` is high from the next cycle until completion.
- R9: `done` is high for exactly one cycle at the end of the whole request. In the following cycle `busy` is 0 and `req_ready` is 1.
- R10: A program request with `req_len` 0 starts no bus transaction and raises `done` in the cycle after acceptance.
- R11: `wr_ready` is high only inside a program transaction, and exactly `req_len` data bytes are consumed per program request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | 0 program, 1 small-block erase, 2 large-block erase, 3 full erase |
| req_addr | input | 8*ADDR_BYTES | Start address |
| req_len | input | LEN_W | Program byte count |
| wr_valid | input | 1 | Data byte offered |
| wr_ready | output | 1 | Data byte taken this cycle when valid |
| wr_data | input | 8 | Data byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Acceptance is due one edge after `req_valid` meets `req_ready`, so `busy` is sampled at the falling edge that follows. For a zero-length program, `done` is sampled at that same falling edge. For all other requests the bench counts falling edges until `done`, bounded by a per-request limit. It checks at the next falling edge that the pulse has ended and the block is idle again. Bus-level results are collected by a flash model that logs each chip-select window, including its byte count and address, and returns a programmed number of busy status reads. The bench compares that log with the transaction list worked out from the request. SCK phase length is measured in clock cycles between rising SCK edges inside a byte, and the expected value is 2*`CLK_DIV`.

// File: rtl/spi_nor_pe_pkg.sv
package spi_nor_pe_pkg;

   typedef enum logic [1:0] {
      OP_PROG      = 2'd0,
      OP_ERASE_SUB = 2'd1,
      OP_ERASE_SEC = 2'd2,
      OP_ERASE_ALL = 2'd3
   } nor_op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WREN,
      ST_GAP,
      ST_CMD,
      ST_ADDR,
      ST_DATA,
      ST_POLL_CMD,
      ST_POLL_RD,
      ST_CHECK,
      ST_DONE
   } seq_state_e;

   localparam logic [7:0] CMD_WR_EN     = 8'h06;
   localparam logic [7:0] CMD_PAGE_PROG = 8'h02;
   localparam logic [7:0] CMD_RD_STAT   = 8'h05;
   localparam logic [7:0] CMD_ER_SMALL  = 8'h20;
   localparam logic [7:0] CMD_ER_LARGE  = 8'hD8;
   localparam logic [7:0] CMD_ER_FULL   = 8'hC7;
   localparam logic [7:0] STAT_BUSY_MSK = 8'h01;

   function automatic logic [7:0] op_opcode(input nor_op_e op);
      case (op)
         OP_PROG:      return CMD_PAGE_PROG;
         OP_ERASE_SUB: return CMD_ER_SMALL;
         OP_ERASE_SEC: return CMD_ER_LARGE;
         default:      return CMD_ER_FULL;
      endcase
   endfunction

endpackage

// File: rtl/spi_nor_byte_shifter.sv
module spi_nor_byte_shifter #(
   parameter int CLK_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       idle,
   output logic       byte_done,
   output logic [7:0] rx_byte,
   output logic       sck,
   output logic       mosi
);

   localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   logic       active;
   logic       tick;
   logic [2:0] bit_cnt;
   logic [7:0] tx_sh;

   generate
      if (CLK_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         logic [DIV_W-1:0] div_cnt;
         assign tick = (div_cnt == DIV_W'(CLK_DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               div_cnt <= '0;
            else if (!active || tick) div_cnt <= '0;
            else                      div_cnt <= div_cnt + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         sck       <= 1'b0;
         bit_cnt   <= '0;
         tx_sh     <= '0;
         rx_byte   <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (!active) begin
            if (start) begin
               active  <= 1'b1;
               tx_sh   <= tx_byte;
               bit_cnt <= '0;
               sck     <= 1'b0;
            end
         end else if (tick) begin
            if (!sck) begin
               sck     <= 1'b1;
               rx_byte <= {rx_byte[6:0], miso};
            end else begin
               sck     <= 1'b0;
               tx_sh   <= {tx_sh[6:0], 1'b0};
               bit_cnt <= bit_cnt + 3'd1;
               if (bit_cnt == 3'd7) begin
                  active    <= 1'b0;
                  byte_done <= 1'b1;
               end
            end
         end
      end
   end

   assign idle = !active;
   assign mosi = tx_sh[7];

endmodule

// File: rtl/spi_nor_page_split.sv
module spi_nor_page_split #(
   parameter int PAGE_BYTES = 256,
   parameter int LEN_W      = 16
) (
   input  logic [$clog2(PAGE_BYTES)-1:0] page_off,
   input  logic [LEN_W-1:0]              remain,
   output logic [LEN_W-1:0]              burst_len
);

   logic [LEN_W-1:0] room;

   always_comb begin
      room      = LEN_W'(PAGE_BYTES) - LEN_W'(page_off);
      burst_len = (remain < room) ? remain : room;
   end

endmodule

// File: rtl/spi_nor_seq_ctrl.sv
module spi_nor_seq_ctrl
   import spi_nor_pe_pkg::*;
#(
   parameter int ADDR_BYTES = 3,
   parameter int LEN_W      = 16,
   parameter int CS_GAP     = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [1:0]              req_op,
   input  logic [8*ADDR_BYTES-1:0] req_addr,
   input  logic [LEN_W-1:0]        req_len,
   input  logic                    wr_valid,
   output logic                    wr_ready,
   input  logic [7:0]              wr_data,
   output logic                    busy,
   output logic                    done,
   output logic                    cs_n,
   output logic                    sh_start,
   output logic [7:0]              sh_tx,
   input  logic                    sh_idle,
   input  logic                    sh_done,
   input  logic [7:0]              sh_rx,
   input  logic [LEN_W-1:0]        burst_len,
   output logic [8*ADDR_BYTES-1:0] cur_addr,
   output logic [LEN_W-1:0]        remain
);

   localparam int ADDR_W = 8 * ADDR_BYTES;
   localparam int IDX_W  = $clog2(ADDR_BYTES);
   localparam int GAP_W  = $clog2(CS_GAP + 1);

   seq_state_e        state, gap_ret;
   nor_op_e           op_q;
   logic [GAP_W-1:0]  gap_cnt;
   logic [IDX_W-1:0]  addr_idx;
   logic [ADDR_W-1:0] addr_sh;
   logic [LEN_W-1:0]  burst_left;
   logic              launched;
   logic              wip;
   logic              in_txn;

   always_comb begin
      in_txn = (state == ST_WREN) || (state == ST_CMD) || (state == ST_ADDR) ||
               (state == ST_DATA) || (state == ST_POLL_CMD) || (state == ST_POLL_RD);
      cs_n      = !in_txn;
      req_ready = (state == ST_IDLE);
      busy      = (state != ST_IDLE);
      done      = (state == ST_DONE);
      wr_ready  = (state == ST_DATA) && !launched && sh_idle;
      sh_start  = in_txn && !launched && sh_idle && ((state != ST_DATA) || wr_valid);
      case (state)
         ST_WREN:     sh_tx = CMD_WR_EN;
         ST_CMD:      sh_tx = op_opcode(op_q);
         ST_ADDR:     sh_tx = addr_sh[ADDR_W-1 -: 8];
         ST_DATA:     sh_tx = wr_data;
         ST_POLL_CMD: sh_tx = CMD_RD_STAT;
         default:     sh_tx = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         gap_ret    <= ST_IDLE;
         op_q       <= OP_PROG;
         gap_cnt    <= '0;
         addr_idx   <= '0;
         addr_sh    <= '0;
         burst_left <= '0;
         cur_addr   <= '0;
         remain     <= '0;
         launched   <= 1'b0;
         wip        <= 1'b0;
      end else begin
         if (sh_start)     launched <= 1'b1;
         else if (sh_done) launched <= 1'b0;

         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  op_q     <= nor_op_e'(req_op);
                  cur_addr <= req_addr;
                  remain   <= req_len;
                  if ((nor_op_e'(req_op) == OP_PROG) && (req_len == '0)) state <= ST_DONE;
                  else                                                 state <= ST_WREN;
               end
            end
            ST_WREN: begin
               if (sh_done) begin
                  state   <= ST_GAP;
                  gap_ret <= ST_CMD;
                  gap_cnt <= '0;
               end
            end
            ST_GAP: begin
               if (gap_cnt == GAP_W'(CS_GAP - 1)) begin
                  state <= gap_ret;
                  if (gap_ret == ST_CMD) burst_left <= burst_len;
               end else begin
                  gap_cnt <= gap_cnt + 1'b1;
               end
            end
            ST_CMD: begin
               if (sh_done) begin
                  addr_idx <= '0;
                  addr_sh  <= cur_addr;
                  if (op_q == OP_ERASE_ALL) begin
                     state   <= ST_GAP;
                     gap_ret <= ST_POLL_CMD;
                     gap_cnt <= '0;
                  end else begin
                     state <= ST_ADDR;
                  end
               end
            end
            ST_ADDR: begin
               if (sh_done) begin
                  addr_sh  <= addr_sh << 8;
                  addr_idx <= addr_idx + 1'b1;
                  if (addr_idx == IDX_W'(ADDR_BYTES - 1)) begin
                     if (op_q == OP_PROG) begin
                        state <= ST_DATA;
                     end else begin
                        state   <= ST_GAP;
                        gap_ret <= ST_POLL_CMD;
                        gap_cnt <= '0;
                     end
                  end
               end
            end
            ST_DATA: begin
               if (sh_done) begin
                  cur_addr   <= cur_addr + 1'b1;
                  remain     <= remain - 1'b1;
                  burst_left <= burst_left - 1'b1;
                  if (burst_left == LEN_W'(1)) begin
                     state   <= ST_GAP;
                     gap_ret <= ST_POLL_CMD;
                     gap_cnt <= '0;
                  end
               end
            end
            ST_POLL_CMD: begin
               if (sh_done) state <= ST_POLL_RD;
            end
            ST_POLL_RD: begin
               if (sh_done) begin
                  wip     <= |(sh_rx & STAT_BUSY_MSK);
                  state   <= ST_GAP;
                  gap_ret <= ST_CHECK;
                  gap_cnt <= '0;
               end
            end
            ST_CHECK: begin
               if (wip)                                   state <= ST_POLL_CMD;
               else if ((op_q == OP_PROG) && (remain != '0)) state <= ST_WREN;
               else                                       state <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/spi_nor_pe_seq.sv
module spi_nor_pe_seq #(
   parameter int CLK_DIV    = 2,
   parameter int ADDR_BYTES = 3,
   parameter int LEN_W      = 16,
   parameter int PAGE_BYTES = 256,
   parameter int CS_GAP     = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [1:0]              req_op,
   input  logic [8*ADDR_BYTES-1:0] req_addr,
   input  logic [LEN_W-1:0]        req_len,
   input  logic                    wr_valid,
   output logic                    wr_ready,
   input  logic [7:0]              wr_data,
   output logic                    busy,
   output logic                    done,
   output logic                    spi_sck,
   output logic                    spi_cs_n,
   output logic                    spi_mosi,
   input  logic                    spi_miso
);

   localparam int ADDR_W = 8 * ADDR_BYTES;
   localparam int PG_W   = $clog2(PAGE_BYTES);

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if ((ADDR_BYTES != 3) && (ADDR_BYTES != 4)) begin : g_bad_addr
         $error("ADDR_BYTES must be 3 or 4");
      end
      if ((PAGE_BYTES < 2) || ((1 << PG_W) != PAGE_BYTES)) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if (LEN_W <= PG_W) begin : g_bad_len
         $error("LEN_W must exceed the page offset width");
      end
      if (CS_GAP < 1) begin : g_bad_gap
         $error("CS_GAP must be at least 1");
      end
   endgenerate

   logic              sh_start, sh_idle, sh_done;
   logic [7:0]        sh_tx, sh_rx;
   logic [LEN_W-1:0]  burst_len, remain;
   logic [ADDR_W-1:0] cur_addr;

   spi_nor_seq_ctrl #(
      .ADDR_BYTES (ADDR_BYTES),
      .LEN_W      (LEN_W),
      .CS_GAP     (CS_GAP)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_op    (req_op),
      .req_addr  (req_addr),
      .req_len   (req_len),
      .wr_valid  (wr_valid),
      .wr_ready  (wr_ready),
      .wr_data   (wr_data),
      .busy      (busy),
      .done      (done),
      .cs_n      (spi_cs_n),
      .sh_start  (sh_start),
      .sh_tx     (sh_tx),
      .sh_idle   (sh_idle),
      .sh_done   (sh_done),
      .sh_rx     (sh_rx),
      .burst_len (burst_len),
      .cur_addr  (cur_addr),
      .remain    (remain)
   );

   spi_nor_page_split #(
      .PAGE_BYTES (PAGE_BYTES),
      .LEN_W      (LEN_W)
   ) u_split (
      .page_off  (cur_addr[PG_W-1:0]),
      .remain    (remain),
      .burst_len (burst_len)
   );

   spi_nor_byte_shifter #(
      .CLK_DIV (CLK_DIV)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (sh_start),
      .tx_byte   (sh_tx),
      .miso      (spi_miso),
      .idle      (sh_idle),
      .byte_done (sh_done),
      .rx_byte   (sh_rx),
      .sck       (spi_sck),
      .mosi      (spi_mosi)
   );

endmodule

// File: rtl/spi_nor_pe_seq_chk.sv
module spi_nor_pe_seq_chk #(
   parameter int CLK_DIV = 2
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic wr_ready,
   input logic busy,
   input logic done,
   input logic spi_sck,
   input logic spi_cs_n
);

   logic [15:0] hi_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_len <= '0;
      else if (spi_sck) hi_len <= hi_len + 16'd1;
      else              hi_len <= '0;
   end

   AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck); // R7

   AST_SCK_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_sck) |-> (hi_len == 16'(CLK_DIV))); // R7

   AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !busy); // R8

   AST_ACCEPT_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> busy); // R8

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (req_ready && !busy)); // R9

   AST_WR_INSIDE_TXN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready |-> !spi_cs_n); // R11

endmodule

bind spi_nor_pe_seq spi_nor_pe_seq_chk #(.CLK_DIV(CLK_DIV)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .wr_ready  (wr_ready),
   .busy      (busy),
   .done      (done),
   .spi_sck   (spi_sck),
   .spi_cs_n  (spi_cs_n)
);

// File: tb/tb_spi_nor_pe_seq.sv
module tb_spi_nor_pe_seq;

   localparam int CLK_DIV    = 2;
   localparam int ADDR_BYTES = 3;
   localparam int LEN_W      = 16;
   localparam int CS_GAP     = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = 2'd0;
   logic [23:0] req_addr = '0;
   logic [15:0] req_len = '0;
   logic        wr_valid = 1'b0;
   logic        wr_ready;
   logic [7:0]  wr_data = '0;
   logic        busy, done;
   logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

   always #4 clk = ~clk;

   spi_nor_pe_seq #(
      .CLK_DIV(CLK_DIV), .ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W), .PAGE_BYTES(256), .CS_GAP(CS_GAP)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_addr(req_addr), .req_len(req_len), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_data(wr_data), .busy(busy), .done(done), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   int n_tests = 0;
   int n_fail  = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- flash model ----------------
   int          clk_cnt = 0;
   int          m_bits = 0;
   int          m_nb = 0;
   logic [7:0]  m_sh = '0;
   logic [7:0]  bytes_buf [0:319];
   int          log_op   [0:63];
   int          log_nb   [0:63];
   int          log_addr [0:63];
   bit          log_wel  [0:63];
   int          txn_n = 0;
   int          busy_cfg = 0;
   int          busy_left = 0;
   bit          wel = 1'b0;
   logic [7:0]  mem [int];
   int          sck_cs_viol = 0;
   int          last_rise = 0;
   int          per_min = 1000000;
   int          per_max = 0;
   logic [7:0]  stat;

   always @(posedge clk) clk_cnt <= clk_cnt + 1;

   assign stat = {6'b0, wel, (busy_left != 0)};
   assign spi_miso = (!spi_cs_n && m_bits >= 8 && m_bits < 16 && bytes_buf[0] == 8'h05)
                     ? stat[15 - m_bits] : 1'b0;

   always @(negedge spi_cs_n) begin
      m_bits = 0;
      m_nb   = 0;
      if (spi_sck === 1'b1) sck_cs_viol++;
   end

   always @(posedge spi_sck) begin
      if (spi_cs_n !== 1'b0) begin
         sck_cs_viol++;
      end else begin
         if (m_bits % 8 != 0) begin
            if (clk_cnt - last_rise < per_min) per_min = clk_cnt - last_rise;
            if (clk_cnt - last_rise > per_max) per_max = clk_cnt - last_rise;
         end
         last_rise = clk_cnt;
         m_sh = {m_sh[6:0], spi_mosi};
         m_bits++;
         if (m_bits % 8 == 0 && m_nb < 320) begin
            bytes_buf[m_nb] = m_sh;
            m_nb++;
         end
      end
   end

   always @(posedge spi_cs_n) begin
      if (m_bits > 0) begin
         if (spi_sck === 1'b1) sck_cs_viol++;
         if (txn_n < 64) begin
            log_op[txn_n]   = int'(bytes_buf[0]);
            log_nb[txn_n]   = m_nb;
            log_addr[txn_n] = (m_nb >= 4) ? int'({bytes_buf[1], bytes_buf[2], bytes_buf[3]}) : -1;
            log_wel[txn_n]  = wel;
         end
         txn_n++;
         case (bytes_buf[0])
            8'h06: if (m_nb == 1) wel = 1'b1;
            8'h02: begin
               for (int i = 4; i < m_nb; i++) begin
                  int a;
                  a = int'({bytes_buf[1], bytes_buf[2], bytes_buf[3]}) + i - 4;
                  mem[a] = bytes_buf[i];
               end
               wel = 1'b0;
               busy_left = busy_cfg;
            end
            8'h20, 8'hD8, 8'hC7: begin
               wel = 1'b0;
               busy_left = busy_cfg;
            end
            8'h05: if (busy_left > 0) busy_left--;
            default: ;
         endcase
      end
   end

   // ---------------- helpers ----------------
   function automatic logic [7:0] pat(input int a);
      return 8'((a * 13) + 7);
   endfunction

   int fed_cnt;
   int req_cycles;

   task automatic run_req(input logic [1:0] op, input int addr, input int len, input int polls);
      bit timeout;
      timeout  = 1'b0;
      busy_cfg = polls;
      fed_cnt  = 0;
      @(negedge clk);
      req_valid = 1'b1;
      req_op    = op;
      req_addr  = 24'(addr);
      req_len   = 16'(len);
      chk(req_ready == 1'b1, "R8", "req_ready before accept", req_ready, 1);
      @(posedge clk);
      fork
         begin
            int cyc;
            cyc = 0;
            @(negedge clk);
            req_valid = 1'b0;
            cyc = 1;
            chk(busy == 1'b1, "R8", "busy after accept", busy, 1);
            while (!done && cyc < 40000) begin
               @(negedge clk);
               cyc++;
            end
            if (!done) begin
               timeout = 1'b1;
               chk(1'b0, "R9", "watchdog: done never seen", 0, 1);
            end
            req_cycles = cyc;
            @(negedge clk);
            chk(!done && !busy && req_ready, "R9", "idle after done pulse",
                {done, busy, req_ready}, 3'b001);
         end
         begin
            if (op == 2'd0) begin
               int k;
               k = 0;
               while (k < len && !timeout) begin
                  @(negedge clk);
                  wr_valid = 1'b1;
                  wr_data  = pat(addr + k);
                  if (wr_ready) begin
                     @(posedge clk);
                     k++;
                  end
               end
               @(negedge clk);
               wr_valid = 1'b0;
               fed_cnt = k;
            end
         end
      join
      if (op == 2'd0) chk(fed_cnt == len, "R11", "data bytes consumed", fed_cnt, len);
   endtask

   task automatic exp_txn(input int idx, input int op, input int nb, input string req);
      chk(log_op[idx] == op, req, $sformatf("txn %0d opcode", idx), log_op[idx], op);
      chk(log_nb[idx] == nb, req, $sformatf("txn %0d byte count", idx), log_nb[idx], nb);
   endtask

   task automatic exp_oper(input int idx, input int op, input int nb, input int addr, input string req);
      exp_txn(idx - 1, 8'h06, 1, "R2");
      chk(log_wel[idx] == 1'b1, "R2", $sformatf("txn %0d write enable latched", idx), log_wel[idx], 1);
      exp_txn(idx, op, nb, req);
      if (addr >= 0)
         chk(log_addr[idx] == addr, req, $sformatf("txn %0d address", idx), log_addr[idx], addr);
   endtask

   task automatic check_mem(input int addr, input int len, input string req);
      int bad;
      bad = 0;
      for (int i = 0; i < len; i++) begin
         if (!mem.exists(addr + i)) bad++;
         else if (mem[addr + i] != pat(addr + i)) bad++;
      end
      chk(bad == 0, req, "programmed bytes mismatching", bad, 0);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      chk(spi_cs_n == 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
      chk(spi_sck == 1'b0, "R1", "sck after reset", spi_sck, 0);
      chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
      chk(done == 1'b0, "R1", "done after reset", done, 0);
      chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
   endtask

   task automatic t_small_prog;
      int s;
      s = txn_n;
      run_req(2'd0, 'h000010, 4, 2);
      chk(txn_n - s == 5, "R6", "transactions for 4-byte program with 2 busy reads", txn_n - s, 5);
      exp_oper(s + 1, 8'h02, 8, 'h000010, "R3");
      exp_txn(s + 2, 8'h05, 2, "R6");
      exp_txn(s + 3, 8'h05, 2, "R6");
      exp_txn(s + 4, 8'h05, 2, "R6");
      check_mem('h000010, 4, "R3");
   endtask

   task automatic t_cross_page;
      int s;
      s = txn_n;
      run_req(2'd0, 'h0000F0, 40, 0);
      chk(txn_n - s == 6, "R4", "transactions for page-crossing program", txn_n - s, 6);
      exp_oper(s + 1, 8'h02, 4 + 16, 'h0000F0, "R4");
      exp_txn(s + 2, 8'h05, 2, "R6");
      exp_oper(s + 4, 8'h02, 4 + 24, 'h000100, "R4");
      exp_txn(s + 5, 8'h05, 2, "R6");
      check_mem('h0000F0, 40, "R3");
   endtask

   task automatic t_long_prog;
      int s;
      s = txn_n;
      run_req(2'd0, 'h000200, 300, 1);
      chk(txn_n - s == 8, "R4", "transactions for 300-byte program", txn_n - s, 8);
      exp_oper(s + 1, 8'h02, 4 + 256, 'h000200, "R4");
      exp_txn(s + 2, 8'h05, 2, "R6");
      exp_txn(s + 3, 8'h05, 2, "R6");
      exp_oper(s + 5, 8'h02, 4 + 44, 'h000300, "R4");
      exp_txn(s + 7, 8'h05, 2, "R6");
      check_mem('h000200, 300, "R3");
   endtask

   task automatic t_erase(input logic [1:0] op, input int addr, input int opc, input int nb);
      int s;
      s = txn_n;
      run_req(op, addr, 0, 1);
      chk(txn_n - s == 4, "R5", "transactions for erase", txn_n - s, 4);
      exp_oper(s + 1, opc, nb, (nb >= 4) ? addr : -1, "R5");
      exp_txn(s + 2, 8'h05, 2, "R6");
      exp_txn(s + 3, 8'h05, 2, "R6");
   endtask

   task automatic t_zero_len;
      int s;
      s = txn_n;
      run_req(2'd0, 'h000400, 0, 0);
      chk(req_cycles == 1, "R10", "cycles from accept to done", req_cycles, 1);
      chk(txn_n == s, "R10", "bus transactions for zero length", txn_n - s, 0);
   endtask

   task automatic t_sck_timing;
      chk(per_min == 2 * CLK_DIV, "R7", "shortest SCK period in cycles", per_min, 2 * CLK_DIV);
      chk(per_max == 2 * CLK_DIV, "R7", "longest SCK period in cycles", per_max, 2 * CLK_DIV);
      chk(sck_cs_viol == 0, "R7", "SCK high while deselected", sck_cs_viol, 0);
   endtask

   initial begin
      #(8 * 180000);
      chk(1'b0, "R9", "global watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_small_prog();
      t_cross_page();
      t_long_prog();
      t_erase(2'd1, 'h012345, 8'h20, 4);
      t_erase(2'd2, 'h0A0000, 8'hD8, 4);
      t_erase(2'd3, 'h000000, 8'hC7, 1);
      t_zero_len();
      t_sck_timing();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule